// File: doc/BRIEF.md
# Watchdog Timer with Two-Step Refresh

This block is a watchdog peripheral for a small 8-bit controller. Software programs a 7-bit reload value, then writes a start command. From then on a prescaled up-counter runs toward overflow. Once running, the watchdog cannot be stopped by software. If the counter overflows, the block pulses a reset request, records the event in a status flag, falls back to the idle state and clears the reload value.

The counter can only be restarted ("kicked") by a strict pair of writes. First comes an arm command. The very next register write must then be a start command. Any other write in between throws the arm away, so a single stray write cannot keep a runaway program alive. On every start or kick, the counter's upper bits take the reload value, its lower bits are cleared, and the prescaler restarts from zero.

Top module: `wdog_top`

## Requirements
- R1: After rst_n is asserted low, rst_req_o, active_o and status_o are 0 and reload_o is 0.
- R2: A write to address 0 stores wr_data[6:0] into the reload register at any time, running or not. Bit 7 is dropped, so writing 0xFF gives reload_o = 0x7F.
- R3: When the block is idle, a write to address 2 with wr_data[0]=1 sets active_o. It also loads the counter with the reload value in its upper RLD_W bits and zeros below, and clears the prescaler. The first rst_req_o pulse then follows exactly 2^PRESC_W * (2^CNT_W - reload * 2^(CNT_W-RLD_W)) clock edges after the start edge.
- R4: While active, no register write clears active_o. Only an overflow does.
- R5: A write to address 1 with wr_data[0]=1 arms a refresh. If the next register write, with idle cycles allowed in between, is a start write, the counter and prescaler are reloaded. The overflow then comes R3's count of edges after that start edge, using the reload value current at that time.
- R6: The arm is discarded by any register write other than the start write that completes it. A start write while active without a pending arm has no effect on the overflow time.
- R7: On overflow, rst_req_o is high for exactly one cycle. In the same edge, status_o is set to 1, active_o is cleared and reload_o is cleared to 0.
- R8: A write to address 3 sets status_o to wr_data[0]. An overflow in the same cycle takes priority and sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (external or power-on) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 reload, 1 arm, 2 start, 3 status |
| wr_data | input | 8 | Write data |
| rst_req_o | output | 1 | One-cycle reset request on overflow |
| active_o | output | 1 | Watchdog running |
| status_o | output | 1 | Watchdog overflow status flag |
| reload_o | output | RLD_W | Current reload register value |

## Verification
On every cycle, the assertions check the following. The reset request is a single-cycle pulse. Each pulse coincides with a set status flag, an idle watchdog and a cleared reload register. A running watchdog drops out only through overflow. A pending arm does not survive an unrelated write, and activation is always preceded by a start write. Only the bench scenarios can show the overflow timing itself, because that depends on the count. These scenarios cover the exact cycle count from a start or from a completed kick, that a discarded arm or a lone start leaves the original deadline unchanged, and the software access to the status flag.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WA_RELOAD = 2'd0,
    WA_ARM    = 2'd1,
    WA_START  = 2'd2,
    WA_STATUS = 2'd3
  } wdog_addr_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int RLD_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ovf_i,
  output logic              load_o,
  output logic              active_o,
  output logic              status_o,
  output logic [RLD_W-1:0]  reload_o
);
  logic             arm_q, arm_d;
  logic             active_q, active_d;
  logic             status_q, status_d;
  logic [RLD_W-1:0] reload_q, reload_d;
  logic             start_wr, arm_wr, reload_wr, status_wr;

  always_comb begin
    start_wr  = wr_en && (wr_addr == WA_START) && wr_data[0];
    arm_wr    = wr_en && (wr_addr == WA_ARM) && wr_data[0];
    reload_wr = wr_en && (wr_addr == WA_RELOAD);
    status_wr = wr_en && (wr_addr == WA_STATUS);
    load_o    = start_wr && !ovf_i && (!active_q || arm_q);
  end

  always_comb begin
    arm_d    = arm_q;
    active_d = active_q;
    status_d = status_q;
    reload_d = reload_q;
    if (wr_en) arm_d = arm_wr;
    if (load_o) active_d = 1'b1;
    if (status_wr) status_d = wr_data[0];
    if (reload_wr) reload_d = wr_data[RLD_W-1:0];
    if (ovf_i) begin
      arm_d    = 1'b0;
      active_d = 1'b0;
      status_d = 1'b1;
      reload_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q    <= 1'b0;
      active_q <= 1'b0;
      status_q <= 1'b0;
      reload_q <= '0;
    end else begin
      arm_q    <= arm_d;
      active_q <= active_d;
      status_q <= status_d;
      reload_q <= reload_d;
    end
  end

  assign active_o = active_q;
  assign status_o = status_q;
  assign reload_o = reload_q;

  // R4
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !ovf_i |=> active_q);
  // R6
  arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !(wr_addr == WA_ARM && wr_data[0]) |=> !arm_q);
  // R7
  ovf_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |=> status_q && !active_q);
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int CNT_W   = 15,
  parameter int RLD_W   = 7,
  parameter int PRESC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [RLD_W-1:0] reload_i,
  output logic             ovf_o
);
  localparam int LOW_W = CNT_W - RLD_W;

  logic [PRESC_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d, load_val;
  logic               tick, en;

  generate
    if (LOW_W > 0) begin : g_pad
      assign load_val = {reload_i, {LOW_W{1'b0}}};
    end else begin : g_flat
      assign load_val = reload_i[CNT_W-1:0];
    end
  endgenerate

  always_comb begin
    tick  = run_i && (pre_q == {PRESC_W{1'b1}});
    ovf_o = tick && (cnt_q == {CNT_W{1'b1}});
    en    = load_i || run_i;
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (load_i) begin
      pre_d = '0;
      cnt_d = load_val;
    end else if (run_i) begin
      pre_d = pre_q + 1'b1;
      if (tick) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int RLD_W   = 7,
  parameter int PRESC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic             rst_req_o,
  output logic             active_o,
  output logic             status_o,
  output logic [RLD_W-1:0] reload_o
);
  logic ovf, load, req_q;

  wdog_regs #(.RLD_W(RLD_W), .DATA_W(8)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ovf_i(ovf), .load_o(load), .active_o(active_o),
    .status_o(status_o), .reload_o(reload_o)
  );

  wdog_core #(.CNT_W(CNT_W), .RLD_W(RLD_W), .PRESC_W(PRESC_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run_i(active_o), .load_i(load),
    .reload_i(reload_o), .ovf_o(ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= ovf;
  end
  assign rst_req_o = req_q;

  // R7
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
  // R7
  req_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> status_o && !active_o && (reload_o == '0));
  // R3
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(wr_en && wr_addr == WA_START && wr_data[0]));
endmodule

// File: tb/sim_wdog_top.sv
module sim_wdog_top;
  localparam int CLK_P = 10;
  localparam int CW = 11, RW = 7, PW = 2;
  localparam int WAIT_MAX = 20000;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic rst_req_o, active_o, status_o;
  logic [RW-1:0] reload_o;
  int cyc = 0, n_chk = 0, n_err = 0;

  wdog_top #(.CNT_W(CW), .RLD_W(RW), .PRESC_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rst_req_o(rst_req_o), .active_o(active_o),
    .status_o(status_o), .reload_o(reload_o)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (cyc > 190000) begin
    n_err++; n_chk++;
    $display("FAIL watchdog timeout act=%0d exp<190000", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  function automatic int exp_edges(input int r);
    return (1 << PW) * ((1 << CW) - (r << (CW - RW)));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_req(input int t0, output int el);
    int n = 0;
    while (!rst_req_o && n < WAIT_MAX) begin @(negedge clk); n++; end
    el = rst_req_o ? cyc - t0 : -1;
  endtask

  task automatic after_ovf(input string tag);
    chk({tag, " R7 status"}, status_o, 1);
    chk({tag, " R7 active"}, active_o, 0);
    chk({tag, " R7 reload"}, reload_o, 0);
    @(negedge clk);
    chk({tag, " R7 pulse width"}, rst_req_o, 0);
  endtask

  initial begin
    int t0, el, r, r2, d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 req", rst_req_o, 0);
    chk("R1 active", active_o, 0);
    chk("R1 status", status_o, 0);
    chk("R1 reload", reload_o, 0);

    wr(2'd0, 8'hFF); chk("R2 bit7 dropped", reload_o, 8'h7F);
    wr(2'd0, 8'h05); chk("R2 plain write", reload_o, 5);

    // R3 / R7: plain start and overflow
    wr(2'd0, 8'd100); wr(2'd2, 8'h01); t0 = cyc;
    chk("R3 active", active_o, 1);
    wait_req(t0, el); chk("R3 overflow time", el, exp_edges(100));
    after_ovf("plain");

    // R8: software status access
    wr(2'd3, 8'h00); chk("R8 clear", status_o, 0);
    wr(2'd3, 8'h01); chk("R8 set", status_o, 1);
    wr(2'd3, 8'h00); chk("R8 clear again", status_o, 0);

    // R4 / R6: writes while running neither stop nor kick
    wr(2'd0, 8'd110); wr(2'd2, 8'h01); t0 = cyc;
    wr(2'd2, 8'h00); wr(2'd3, 8'h00); wr(2'd2, 8'h01);
    wr(2'd0, 8'd120);
    chk("R2 write while active", reload_o, 120);
    chk("R4 still active", active_o, 1);
    wait_req(t0, el); chk("R6 lone start ignored", el, exp_edges(110));
    after_ovf("lone");

    // R5: kick with idle cycles between arm and start
    wr(2'd0, 8'd120); wr(2'd2, 8'h01);
    repeat (40) @(negedge clk);
    wr(2'd1, 8'h01); repeat (3) @(negedge clk);
    wr(2'd2, 8'h01); t0 = cyc;
    wait_req(t0, el); chk("R5 kick time", el, exp_edges(120));
    after_ovf("kick");

    // R6: arm then unrelated write then start -> no kick
    wr(2'd0, 8'd120); wr(2'd2, 8'h01); t0 = cyc;
    repeat (20) @(negedge clk);
    wr(2'd1, 8'h01); wr(2'd0, 8'd127); wr(2'd2, 8'h01);
    wait_req(t0, el); chk("R6 arm cancelled", el, exp_edges(120));
    after_ovf("cancel");

    // R3 / R5: random reloads, random kick points
    for (int i = 0; i < 5; i++) begin
      r = int'($urandom % 128);
      r2 = int'($urandom % 128);
      wr(2'd0, 8'(r)); wr(2'd2, 8'h01); t0 = cyc;
      if (i % 2 == 0) begin
        wait_req(t0, el); chk("R3 random overflow", el, exp_edges(r));
      end else begin
        d = int'($urandom % 30);
        repeat (d) @(negedge clk);
        wr(2'd0, 8'(r2)); wr(2'd1, 8'h01); wr(2'd2, 8'h01); t0 = cyc;
        wait_req(t0, el); chk("R5 random kick", el, exp_edges(r2));
      end
      after_ovf("random");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule